// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

After reset this block becomes the only master on a two-wire serial bus. It reads a block of configuration bytes from an attached EEPROM and turns each byte into a write strobe on a local register port. Byte N always goes to register N. One parameter mask marks registers that must never be written; their bytes are still read from the EEPROM, so every later byte stays at its own address. The first byte must equal a fixed signature. If it does not, the whole load is refused.

The bus lines are open-drain. The block only ever pulls SCL or SDA low through an output enable, and it reads SDA back through a separate input. SCL is output-only: slave clock stretching is not supported. The bit rate comes from `QTR_CYCLES`, the number of system clocks in one quarter of an SCL period. The whole transfer is 1119 bit slots, which is 4 × `QTR_CYCLES` × 1119 clocks plus a few clocks between bus operations. The default of 79 at 125 MHz gives about 2.8 ms, well inside a 15 ms boot budget.

The register port is a bare one-cycle strobe with no ready signal. Because the port has no back-pressure, the receiving register file must accept a write on any cycle. Successive strobes are at least 36 × `QTR_CYCLES` clocks apart. `load_done` and `load_abort` are plain status pins.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: The mode strap and the active-low power-down input are sampled on every clock edge while `rst_n` is low, and the values at the last such edge decide whether a load runs. A load runs only if the strap was 2'b00 and power-down was high. Otherwise both bus enables stay low, no write strobe occurs, and `load_done` and `load_abort` stay low. All outputs are low during reset.
- R2: The bus transfer is, in order: START, byte 0xA0, byte 0x00, repeated START, byte 0xA1, then `NREG` (121) data bytes read in sequence, then STOP. That is exactly two START conditions and one STOP.
- R3: The master sends ACK (SDA low in the ninth bit) after each of data bytes 0 to `NREG`-2. It sends NACK (SDA released) after the last data byte.
- R4: Data byte N produces one single-cycle strobe with `reg_addr` = N and `reg_data` equal to the byte. Strobes come in ascending address order and never for an address above `NREG`-1.
- R5: If data byte 0 is not 8'h88, `load_abort` rises and no strobe ever occurs in that load. The remaining bytes are still read and the transfer still ends with NACK and STOP as in R2 and R3.
- R6: A register whose bit is set in `RO_MASK` gets no strobe. Its byte is still consumed, so all later bytes still reach their own addresses.
- R7: If any of the three address bytes (0xA0, 0x00, 0xA1) is not acknowledged, `load_abort` rises and STOP is issued at once. No data byte is read and no strobe occurs.
- R8: After a good load, `load_done` pulses high for exactly one cycle once the STOP is complete, with both bus lines released. `load_abort` stays high until the next reset. The two are never high together.
- R9: Every SCL high time lasts exactly 2 × `QTR_CYCLES` clocks. SDA changes while SCL is high only to form START or STOP.
- R10: A good load asserts `load_done` within 4 × `QTR_CYCLES` × 1119 + 512 clocks of reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pwr_dn_n | input | 1 | Active-low power-down; low during reset inhibits the load |
| mode_strap | input | 2 | Boot mode strap; 2'b00 selects EEPROM loading |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed level of the SDA line |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register index for the strobe |
| reg_data | output | 8 | Register data for the strobe |
| load_done | output | 1 | One-cycle pulse on a successful load |
| load_abort | output | 1 | Sticky flag for a refused or failed load |

## Verification
The hardest cases to reach from the ports are an EEPROM that refuses one particular address byte, and a signature failure that still has to clock out all remaining bytes and end cleanly. The bench's behavioural EEPROM decodes START, STOP and each ninth bit from the sampled bus levels. It can be told to withhold ACK on the device-write, word-address or device-read byte, and its memory can hold a bad first byte. A cycle-by-cycle write queue built from the requirements then confirms both that no strobe appears and that the bus still ends with the expected NACK and STOP.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_START_W,
    ST_DEV_W,
    ST_WORD,
    ST_START_R,
    ST_DEV_R,
    ST_READ,
    ST_STOP,
    ST_HALT
  } load_state_e;

  localparam int unsigned BYTE_BITS = 9;

endpackage

// File: rtl/cfg_qtr_tick.sv
module cfg_qtr_tick #(
  parameter int unsigned QTR_CYCLES = 79
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!en)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/cfg_i2c_phy.sv
module cfg_i2c_phy
  import cfg_loader_pkg::*;
#(
  parameter int unsigned QTR_CYCLES = 79
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  bus_cmd_e   cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_nack,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic       rsp_ack,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic       busy_q, tick, last_bit, scl_c, sda_c;
  bus_cmd_e   op_q;
  logic [7:0] tx_q, rx_q;
  logic       nack_q, ack_q, rsp_q, scl_q, sda_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;

  cfg_qtr_tick #(.QTR_CYCLES(QTR_CYCLES)) tick_i (
    .clk(clk), .rst_n(rst_n), .en(busy_q), .tick(tick)
  );

  assign last_bit = (op_q == BC_START || op_q == BC_STOP) ? (bit_q == 4'd0)
                                                          : (bit_q == 4'd8);

  // quarter-phase waveform; SCL high in phases 1 and 2
  always_comb begin
    scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
    sda_c = 1'b0;
    case (op_q)
      BC_START: begin
        scl_c = (ph_q == 2'd0) || (ph_q == 2'd3);
        sda_c = ph_q[1];
      end
      BC_STOP: begin
        scl_c = (ph_q == 2'd0);
        sda_c = !ph_q[1];
      end
      BC_WRITE: sda_c = (bit_q < 4'd8) ? !tx_q[3'(4'd7 - bit_q)] : 1'b0;
      BC_READ:  sda_c = (bit_q == 4'd8) && !nack_q;
      default:  sda_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; op_q <= BC_START; tx_q <= '0; rx_q <= '0;
      nack_q <= 1'b0; ack_q <= 1'b0; rsp_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0; ph_q <= '0; bit_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q <= 1'b1; op_q <= cmd_op; tx_q <= cmd_byte;
          nack_q <= cmd_nack; ph_q <= '0; bit_q <= '0;
        end
      end else begin
        scl_q <= scl_c;
        sda_q <= sda_c;
        if (tick) begin
          if (ph_q == 2'd2 && op_q == BC_READ && bit_q < 4'd8)
            rx_q <= {rx_q[6:0], sda_in};
          if (ph_q == 2'd2 && bit_q == 4'd8)
            ack_q <= !sda_in;
          if (ph_q == 2'd3) begin
            ph_q <= '0;
            if (last_bit) begin
              busy_q <= 1'b0;
              rsp_q  <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign rsp_valid = rsp_q;
  assign rsp_byte  = rx_q;
  assign rsp_ack   = ack_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_loader_pkg::*;
#(
  parameter int unsigned  NREG     = 121,
  parameter logic [7:0]   SIG_BYTE = 8'h88,
  parameter logic [6:0]   DEV_ADDR = 7'h50,
  parameter logic [NREG-1:0] RO_MASK = '0,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn_n,
  input  logic [1:0]    mode_strap,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output bus_cmd_e      cmd_op,
  output logic [7:0]    cmd_byte,
  output logic          cmd_nack,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_byte,
  input  logic          rsp_ack,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_data,
  output logic          load_done,
  output logic          load_abort
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  load_state_e   state_q;
  logic          wait_q, abort_q, done_q, wr_q, pd_q, keep;
  logic [1:0]    strap_q;
  logic [AW-1:0] idx_q, addr_q;
  logic [7:0]    data_q;

  // boot straps follow the pins while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= mode_strap;
      pd_q    <= !pwr_dn_n;
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = BC_START;
    cmd_byte  = 8'h00;
    cmd_nack  = 1'b0;
    case (state_q)
      ST_START_W, ST_START_R: cmd_valid = !wait_q;
      ST_DEV_W: begin cmd_valid = !wait_q; cmd_op = BC_WRITE; cmd_byte = {DEV_ADDR, 1'b0}; end
      ST_WORD:  begin cmd_valid = !wait_q; cmd_op = BC_WRITE; cmd_byte = 8'h00; end
      ST_DEV_R: begin cmd_valid = !wait_q; cmd_op = BC_WRITE; cmd_byte = {DEV_ADDR, 1'b1}; end
      ST_READ:  begin cmd_valid = !wait_q; cmd_op = BC_READ; cmd_nack = (idx_q == LAST); end
      ST_STOP:  begin cmd_valid = !wait_q; cmd_op = BC_STOP; end
      default:  cmd_valid = 1'b0;
    endcase
  end

  // byte 0 must match the signature; afterwards a set abort flag blocks writes
  assign keep = (idx_q == '0) ? (rsp_byte == SIG_BYTE) : !abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT; wait_q <= 1'b0; abort_q <= 1'b0; done_q <= 1'b0;
      wr_q <= 1'b0; idx_q <= '0; addr_q <= '0; data_q <= '0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      if (state_q == ST_BOOT) begin
        state_q <= (strap_q == 2'b00 && !pd_q) ? ST_START_W : ST_HALT;
      end else if (!wait_q) begin
        if (cmd_valid && cmd_ready) wait_q <= 1'b1;
      end else if (rsp_valid) begin
        wait_q <= 1'b0;
        case (state_q)
          ST_START_W: state_q <= ST_DEV_W;
          ST_START_R: state_q <= ST_DEV_R;
          ST_DEV_W, ST_WORD, ST_DEV_R: begin
            if (!rsp_ack) begin
              abort_q <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              state_q <= (state_q == ST_DEV_W) ? ST_WORD :
                         (state_q == ST_WORD)  ? ST_START_R : ST_READ;
            end
          end
          ST_READ: begin
            if (idx_q == '0 && rsp_byte != SIG_BYTE) abort_q <= 1'b1;
            if (keep && !RO_MASK[idx_q]) begin
              wr_q   <= 1'b1;
              addr_q <= idx_q;
              data_q <= rsp_byte;
            end
            if (idx_q == LAST) state_q <= ST_STOP;
            else               idx_q   <= idx_q + 1'b1;
          end
          ST_STOP: begin
            done_q  <= !abort_q;
            state_q <= ST_HALT;
          end
          default: state_q <= ST_HALT;
        endcase
      end
    end
  end

  assign reg_wr     = wr_q;
  assign reg_addr   = addr_q;
  assign reg_data   = data_q;
  assign load_done  = done_q;
  assign load_abort = abort_q;
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned     QTR_CYCLES = 79,
  parameter int unsigned     NREG       = 121,
  parameter logic [7:0]      SIG_BYTE   = 8'h88,
  parameter logic [6:0]      DEV_ADDR   = 7'h50,
  parameter logic [NREG-1:0] RO_MASK    = {{(NREG-1){1'b0}}, 1'b1},
  localparam int unsigned    AW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn_n,
  input  logic [1:0]    mode_strap,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_data,
  output logic          load_done,
  output logic          load_abort
);
  logic       cmd_valid, cmd_ready, cmd_nack, rsp_valid, rsp_ack;
  bus_cmd_e   cmd_op;
  logic [7:0] cmd_byte, rsp_byte;

  cfg_load_seq #(
    .NREG(NREG), .SIG_BYTE(SIG_BYTE), .DEV_ADDR(DEV_ADDR), .RO_MASK(RO_MASK)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .mode_strap(mode_strap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ack(rsp_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .load_done(load_done), .load_abort(load_abort)
  );

  cfg_i2c_phy #(.QTR_CYCLES(QTR_CYCLES)) phy_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ack(rsp_ack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned     NREG    = 121,
  parameter logic [NREG-1:0] RO_MASK = '0,
  localparam int unsigned    AW      = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          load_done,
  input logic          load_abort
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);                                    // R8
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    load_abort |=> load_abort);                                   // R8
  AST_DONE_NOT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_abort));                                  // R8
  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!scl_oe && !sda_oe));                          // R8
  AST_NO_WR_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    load_abort |-> !reg_wr);                                      // R5
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (int'(reg_addr) < NREG));                          // R4
  AST_WR_NOT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !RO_MASK[reg_addr]);                               // R6
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && $past(reg_wr) |-> 1'b0);                            // R4
endmodule

bind cfg_eeprom_loader cfg_loader_chk #(.NREG(NREG), .RO_MASK(RO_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .load_done(load_done), .load_abort(load_abort)
);

// File: tb/cfg_eeprom_loader_tb_top.sv
module cfg_eeprom_loader_tb_top;
  localparam int unsigned QTR  = 4;
  localparam int unsigned NREG = 121;
  localparam logic [NREG-1:0] RO = (NREG'(1) << 5) | (NREG'(1) << 64) | (NREG'(1) << 120);
  localparam int BOUND = 4 * QTR * 1119 + 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn_n = 1'b1;
  logic [1:0] mode_strap = 2'b00;
  logic scl_oe, sda_oe, sda_in, reg_wr, load_done, load_abort;
  logic [6:0] reg_addr;
  logic [7:0] reg_data;
  logic slv_drv = 1'b0;

  always #4 clk = !clk;

  assign sda_in = !(sda_oe || slv_drv);

  cfg_eeprom_loader #(.QTR_CYCLES(QTR), .NREG(NREG), .RO_MASK(RO)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .mode_strap(mode_strap),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .load_done(load_done), .load_abort(load_abort)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural EEPROM
  logic [7:0] mem [128];
  int nack_sel = 0;
  int bitn = 0, bidx = 0, rd_ptr = 0, rb = 0, mack_cnt = 0, nack_idx = -1;
  int starts = 0, stops = 0, hcnt = 0, hmin = 1000000, hmax = 0, act_cnt = 0;
  bit active = 0, reading = 0, go_read = 0, skip = 0, mack = 0;
  logic [7:0] sh = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  logic [7:0] hdr [$];

  always @(negedge clk) begin : eeprom_model
    logic scl_n, sda_n;
    bit ack;
    scl_n = !scl_oe;
    sda_n = !(sda_oe || slv_drv);
    if (scl_oe || sda_oe) act_cnt++;
    if (scl_p && scl_n && hcnt > 0) hcnt++;
    if (scl_p && scl_n && sda_p && !sda_n) begin
      starts++; active = 1; reading = 0; go_read = 0; bitn = 0; bidx = 0;
      skip = 1; slv_drv = 1'b0;
    end else if (scl_p && scl_n && !sda_p && sda_n) begin
      stops++; active = 0; reading = 0; slv_drv = 1'b0;
    end else if (!scl_p && scl_n) begin
      hcnt = 1;
      if (active && !reading && bitn < 8) sh = {sh[6:0], sda_n};
      if (active && reading && bitn == 8) mack = !sda_n;
    end else if (scl_p && !scl_n) begin
      if (hcnt > 0) begin
        if (hcnt < hmin) hmin = hcnt;
        if (hcnt > hmax) hmax = hcnt;
      end
      hcnt = 0;
      if (active) begin
        if (skip) skip = 0;
        else if (!reading) begin
          if (bitn == 7) begin
            bitn = 8;
            hdr.push_back(sh);
            if (bidx == 0) begin
              if (sh == 8'hA0) begin ack = (nack_sel != 1); go_read = 0; end
              else if (sh == 8'hA1) begin ack = (nack_sel != 3); go_read = ack; end
              else ack = 0;
            end else begin
              ack = (nack_sel != 2);
              rd_ptr = int'(sh);
            end
            slv_drv = ack;
            if (!ack) active = 0;
          end else if (bitn == 8) begin
            slv_drv = 1'b0; bitn = 0; bidx++;
            if (go_read) begin
              reading = 1;
              slv_drv = !mem[rd_ptr % 128][7];
            end
          end else bitn++;
        end else begin
          if (bitn < 7) begin
            bitn++;
            slv_drv = !mem[rd_ptr % 128][7 - bitn];
          end else if (bitn == 7) begin
            bitn = 8; slv_drv = 1'b0;
          end else begin
            if (mack) mack_cnt++; else nack_idx = rb;
            rb++; rd_ptr++;
            if (mack) begin bitn = 0; slv_drv = !mem[rd_ptr % 128][7]; end
            else active = 0;
          end
        end
      end
    end
    scl_p = scl_n;
    sda_p = sda_n;
  end

  // per-clock reference: expected write stream and status
  int exp_addr [$];
  int exp_data [$];
  int cyc = 0, done_cnt = 0, done_cyc = -1, ro_wr = 0;

  always @(negedge clk) begin : ref_model
    if (rst_n) begin
      cyc++;
      if (load_done) begin done_cnt++; done_cyc = cyc; end
      if (reg_wr) begin
        if (RO[reg_addr]) ro_wr++;
        if (exp_addr.size() == 0) begin
          chk(0, "R4", "unexpected write strobe addr", int'(reg_addr), -1);
        end else begin
          chk(int'(reg_addr) == exp_addr[0], "R4", "write address", int'(reg_addr), exp_addr[0]);
          chk(int'(reg_data) == exp_data[0], "R4", "write data", int'(reg_data), exp_data[0]);
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
        end
      end
    end
  end

  // kind: 0 good, 1 bad signature, 2 blocked by strap/power-down
  task automatic run_case(input string name, input int kind, input int nsel,
                          input logic [1:0] strap, input logic pd_n);
    int loaded;
    rst_n = 1'b0;
    mode_strap = strap;
    pwr_dn_n = pd_n;
    nack_sel = nsel;
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 255);
    mem[0] = (kind == 1) ? 8'h89 : 8'h88;
    exp_addr.delete(); exp_data.delete(); hdr.delete();
    bitn = 0; bidx = 0; rd_ptr = 0; rb = 0; mack_cnt = 0; nack_idx = -1;
    starts = 0; stops = 0; hcnt = 0; hmin = 1000000; hmax = 0; act_cnt = 0;
    active = 0; reading = 0; slv_drv = 1'b0; cyc = 0; done_cnt = 0;
    done_cyc = -1; ro_wr = 0;
    loaded = (kind == 0 && nsel == 0);
    if (loaded)
      for (int i = 0; i < NREG; i++)
        if (!RO[i]) begin exp_addr.push_back(i); exp_data.push_back(int'(mem[i])); end
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !reg_wr && !load_done && !load_abort, "R1",
        {name, " outputs low in reset"}, int'({scl_oe, sda_oe, reg_wr, load_done, load_abort}), 0);
    act_cnt = 0;
    rst_n = 1'b1;
    for (int c = 0; c < BOUND + 1000; c++) begin
      @(negedge clk);
      if (done_cnt > 0 || (load_abort && stops > 0)) break;
      if (kind == 2 && c > 3000) break;
    end
    repeat (40) @(negedge clk);

    if (kind == 2) begin
      chk(act_cnt == 0, "R1", {name, " bus activity cycles"}, act_cnt, 0);
      chk(done_cnt == 0 && !load_abort, "R1", {name, " status"}, done_cnt + int'(load_abort), 0);
      return;
    end
    chk(exp_addr.size() == 0, "R6", {name, " expected writes left"}, exp_addr.size(), 0);
    chk(ro_wr == 0, "R6", {name, " writes to read-only registers"}, ro_wr, 0);
    chk(stops == 1, "R2", {name, " STOP count"}, stops, 1);
    if (loaded) begin
      chk(done_cnt == 1, "R8", {name, " done pulses"}, done_cnt, 1);
      chk(!load_abort, "R8", {name, " abort"}, int'(load_abort), 0);
      chk(done_cyc >= 0 && done_cyc <= BOUND, "R10", {name, " done cycle"}, done_cyc, BOUND);
      chk(hmin == 2 * QTR && hmax == 2 * QTR, "R9", {name, " SCL high min"}, hmin, 2 * QTR);
      chk(hmax == 2 * QTR, "R9", {name, " SCL high max"}, hmax, 2 * QTR);
    end else begin
      chk(done_cnt == 0, "R8", {name, " done pulses"}, done_cnt, 0);
      chk(load_abort, nsel != 0 ? "R7" : "R5", {name, " abort flag"}, int'(load_abort), 1);
    end
    if (nsel == 0) begin
      chk(starts == 2, "R2", {name, " START count"}, starts, 2);
      chk(hdr.size() == 3, "R2", {name, " header byte count"}, hdr.size(), 3);
      if (hdr.size() == 3) begin
        chk(hdr[0] == 8'hA0, "R2", {name, " device write byte"}, int'(hdr[0]), 'hA0);
        chk(hdr[1] == 8'h00, "R2", {name, " word address byte"}, int'(hdr[1]), 0);
        chk(hdr[2] == 8'hA1, "R2", {name, " device read byte"}, int'(hdr[2]), 'hA1);
      end
      chk(mack_cnt == NREG - 1, "R3", {name, " master ACK count"}, mack_cnt, NREG - 1);
      chk(nack_idx == NREG - 1, "R3", {name, " NACKed byte index"}, nack_idx, NREG - 1);
    end else begin
      chk(rb == 0, "R7", {name, " data bytes read"}, rb, 0);
      chk(starts == (nsel == 3 ? 2 : 1), "R7", {name, " START count"}, starts, nsel == 3 ? 2 : 1);
      chk(hdr.size() == nsel, "R7", {name, " header bytes sent"}, hdr.size(), nsel);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d cycles expected below %0d", 190000, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    run_case("good load", 0, 0, 2'b00, 1'b1);          // R2 R3 R4 R6 R8 R9 R10
    run_case("bad signature", 1, 0, 2'b00, 1'b1);      // R5
    run_case("nack device write", 0, 1, 2'b00, 1'b1);  // R7
    run_case("nack word address", 0, 2, 2'b00, 1'b1);  // R7
    run_case("nack device read", 0, 3, 2'b00, 1'b1);   // R7
    run_case("strap not zero", 2, 0, 2'b01, 1'b1);     // R1
    run_case("power-down in reset", 2, 0, 2'b00, 1'b0);// R1
    run_case("good load again", 0, 0, 2'b00, 1'b1);    // R4 after a blocked boot
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule